// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block turns three serial audio data lines into parallel samples. The lines share one bit clock and one word-select line, and each line carries a stereo pair. Lane 0 carries channels 1 and 2, lane 1 carries channels 3 and 4, and lane 2 carries channels 5 and 6. The bit clock and word select are slow compared with the system clock, so the block samples them in the system clock domain. It acts on each rising edge of the bit clock.

Three framings are supported: I2S, MSB-justified and LSB-justified. The word length can be chosen. The framing comes either from a 2-bit pin code or from a 3-bit register code, and a select input picks which code applies. After the right-channel word of a frame completes, all six channels appear together as left-aligned, zero-filled 24-bit samples, with a one-cycle valid pulse.

Top module: `mfmt_audio_rx`

## Requirements
- R1: With `useReg`=0, the `pinFmt` code selects the framing: 2'b00 is I2S, 2'b01 is LSB-justified 16-bit, 2'b10 is LSB-justified 20-bit and 2'b11 is LSB-justified 24-bit. `regFmt` has no effect in this mode.
- R2: With `useReg`=1, the `regFmt` code selects the framing: 3'b000 is I2S, 3'b001 is LSB-justified 16, 3'b010 is LSB-justified 18, 3'b011 is LSB-justified 20, 3'b100 is MSB-justified, 3'b101 is LSB-justified 24, and 3'b110 and 3'b111 are reserved. `pinFmt` has no effect in this mode.
- R3: In I2S, word select low marks the left word. The MSB arrives in the bit slot after the slot in which word select changes. Bits are sent MSB first, and at most the first 24 bits of a word are kept.
- R4: In MSB-justified framing, word select high marks the left word. The MSB arrives in the same slot as the word-select change, and at most 24 bits are kept.
- R5: In LSB-justified framing, word select high marks the left word. The word's LSB is the last slot before the word-select change, so the slot of the MSB depends on the selected length.
- R6: A word shorter than 24 bits is output left-aligned, with zeros in the unused low bits.
- R7: Lane k left goes to channel 2k+1 and lane k right goes to channel 2k+2. Channel c occupies `samples[24*(c-1) +: 24]`.
- R8: `sampleValid` pulses for exactly one cycle when a right word completes, with exactly one pulse per frame. `samples` changes only in a cycle in which `sampleValid` is high.
- R9: With a reserved register code, every published sample is zero.
- R10: The first word-select change after reset only arms capture. A right word publishes only after a left word has been captured since arming. Any change on `useReg`, `pinFmt` or `regFmt` disarms capture, and no pulse follows in the next cycle.
- R11: During reset and just after it, `sampleValid` is low and `samples` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock, oversampled by clk |
| wordSel | input | 1 | Word select shared by all lanes |
| sdIn | input | NUM_LANES | Serial data, one bit per lane |
| useReg | input | 1 | 1 selects the register code, 0 selects the pin code |
| pinFmt | input | 2 | Pin format code |
| regFmt | input | 3 | Register format code |
| sampleValid | output | 1 | One-cycle pulse when new samples are presented |
| samples | output | 2*NUM_LANES*SAMPLE_W | All channel samples, channel 1 in the low bits |

## Verification
The properties assume that each phase of the bit clock lasts at least one system clock. This means two rising edges can never be seen in adjacent cycles. They also assume that word select and data are steady around each rising edge of the bit clock, and that the format inputs change only when a change is intended. The stimulus stretches every bit slot over several system clocks and moves data and word select only while the bit clock is low. The format inputs are changed only before a reset or, in the one directed disarm case, in the middle of a frame.

// File: rtl/mfmt_rx_pkg.sv
package mfmt_rx_pkg;

  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    MODE_I2S  = 2'd0,
    MODE_MSBJ = 2'd1,
    MODE_LSBJ = 2'd2,
    MODE_OFF  = 2'd3
  } frameMode_e;

  typedef struct packed {
    frameMode_e       mode;
    logic [LEN_W-1:0] lsbLen;
  } fmtCfg_t;

  // strobes from control to every lane, valid for one clk on a bit-clock rise
  typedef struct packed {
    logic             shiftPre;   // shift current bit into the ending word
    logic             restart;    // clear capture for a new word
    logic             shiftPost;  // shift current bit into the new/ongoing word
    logic             capLimit;   // stop shifting after SAMPLE_W bits
    logic             latchLeft;
    logic             latchRight;
    logic             publish;
    logic             zeroOut;
    logic             lsbMode;
    logic [LEN_W-1:0] lsbLen;
  } laneStrb_t;

endpackage

// File: rtl/mfmt_rx_ctrl.sv
module mfmt_rx_ctrl
  import mfmt_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitClk,
  input  logic      wordSel,
  input  logic      useReg,
  input  logic [1:0] pinFmt,
  input  logic [2:0] regFmt,
  output laneStrb_t strb
);

  localparam int SEL_W = 6;

  logic bckQ, bckD, wsQ, wsPrev;
  logic armed, leftSeen;
  logic [SEL_W-1:0] selQ, selNow;
  logic selChg, rise, wsEdge, toLeft;
  fmtCfg_t cfg;

  always_comb begin
    cfg.mode   = MODE_OFF;
    cfg.lsbLen = LEN_W'(24);
    if (!useReg) begin
      unique case (pinFmt)
        2'b00: cfg.mode = MODE_I2S;
        2'b01: begin cfg.mode = MODE_LSBJ; cfg.lsbLen = LEN_W'(16); end
        2'b10: begin cfg.mode = MODE_LSBJ; cfg.lsbLen = LEN_W'(20); end
        default: cfg.mode = MODE_LSBJ;
      endcase
    end else begin
      unique case (regFmt)
        3'b000: cfg.mode = MODE_I2S;
        3'b001: begin cfg.mode = MODE_LSBJ; cfg.lsbLen = LEN_W'(16); end
        3'b010: begin cfg.mode = MODE_LSBJ; cfg.lsbLen = LEN_W'(18); end
        3'b011: begin cfg.mode = MODE_LSBJ; cfg.lsbLen = LEN_W'(20); end
        3'b100: cfg.mode = MODE_MSBJ;
        3'b101: cfg.mode = MODE_LSBJ;
        default: cfg.mode = MODE_OFF;
      endcase
    end
  end

  assign selNow = {useReg, pinFmt, regFmt};
  assign selChg = (selNow != selQ);
  assign rise   = bckQ && !bckD;
  assign wsEdge = rise && (wsQ != wsPrev);
  assign toLeft = (cfg.mode == MODE_I2S) ? !wsPrev : wsPrev;

  always_comb begin
    strb          = '0;
    strb.lsbLen   = cfg.lsbLen;
    strb.lsbMode  = (cfg.mode == MODE_LSBJ);
    strb.zeroOut  = (cfg.mode == MODE_OFF);
    strb.capLimit = (cfg.mode != MODE_LSBJ);
    strb.restart  = wsEdge;
    if (cfg.mode == MODE_I2S) begin
      strb.shiftPre  = wsEdge;
      strb.shiftPost = rise && !wsEdge;
    end else begin
      strb.shiftPost = rise;
    end
    strb.latchLeft  = wsEdge && armed && toLeft && !selChg;
    strb.latchRight = wsEdge && armed && !toLeft && !selChg;
    strb.publish    = strb.latchRight && leftSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bckQ     <= 1'b0;
      bckD     <= 1'b0;
      wsQ      <= 1'b0;
      wsPrev   <= 1'b0;
      selQ     <= '0;
      armed    <= 1'b0;
      leftSeen <= 1'b0;
    end else begin
      bckQ <= bitClk;
      bckD <= bckQ;
      wsQ  <= wordSel;
      selQ <= selNow;
      if (rise) wsPrev <= wsQ;
      if (selChg) begin
        armed    <= 1'b0;
        leftSeen <= 1'b0;
      end else begin
        if (wsEdge) armed <= 1'b1;
        if (strb.latchLeft) leftSeen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mfmt_rx_lane.sv
module mfmt_rx_lane
  import mfmt_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdBit,
  input  laneStrb_t           strb,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] cap, capA, capB, capN, aligned, leftHold, lsbMask;
  logic [CNT_W-1:0]    cnt, cntA, cntB, cntN, lenC;

  always_comb begin
    capA = cap;
    cntA = cnt;
    if (strb.shiftPre && (!strb.capLimit || cnt != FULL)) begin
      capA = {cap[SAMPLE_W-2:0], sdBit};
      if (cnt != FULL) cntA = cnt + 1'b1;
    end

    lenC    = CNT_W'(strb.lsbLen);
    lsbMask = {SAMPLE_W{1'b1}} >> (FULL - lenC);
    if (strb.zeroOut)      aligned = '0;
    else if (strb.lsbMode) aligned = (capA & lsbMask) << (FULL - lenC);
    else                   aligned = capA << (FULL - cntA);

    capB = strb.restart ? '0 : capA;
    cntB = strb.restart ? '0 : cntA;
    capN = capB;
    cntN = cntB;
    if (strb.shiftPost && (!strb.capLimit || cntB != FULL)) begin
      capN = {capB[SAMPLE_W-2:0], sdBit};
      if (cntB != FULL) cntN = cntB + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap      <= '0;
      cnt      <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
    end else begin
      cap <= capN;
      cnt <= cntN;
      if (strb.latchLeft) leftHold <= aligned;
      if (strb.publish) begin
        leftOut  <= leftHold;
        rightOut <= aligned;
      end
    end
  end

endmodule

// File: rtl/mfmt_rx_datapath.sv
module mfmt_rx_datapath
  import mfmt_rx_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int SAMPLE_W  = 24
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_LANES-1:0]              sdIn,
  input  laneStrb_t                         strb,
  output logic                              sampleValid,
  output logic [2*NUM_LANES*SAMPLE_W-1:0]   samples
);

  logic [NUM_LANES-1:0] sdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdQ         <= '0;
      sampleValid <= 1'b0;
    end else begin
      sdQ         <= sdIn;
      sampleValid <= strb.publish;
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    mfmt_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .sdBit    (sdQ[k]),
      .strb     (strb),
      .leftOut  (samples[(2*k)*SAMPLE_W +: SAMPLE_W]),
      .rightOut (samples[(2*k+1)*SAMPLE_W +: SAMPLE_W])
    );
  end

endmodule

// File: rtl/mfmt_audio_rx.sv
module mfmt_audio_rx
  import mfmt_rx_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int SAMPLE_W  = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            bitClk,
  input  logic                            wordSel,
  input  logic [NUM_LANES-1:0]            sdIn,
  input  logic                            useReg,
  input  logic [1:0]                      pinFmt,
  input  logic [2:0]                      regFmt,
  output logic                            sampleValid,
  output logic [2*NUM_LANES*SAMPLE_W-1:0] samples
);

  laneStrb_t strb;

  mfmt_rx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClk  (bitClk),
    .wordSel (wordSel),
    .useReg  (useReg),
    .pinFmt  (pinFmt),
    .regFmt  (regFmt),
    .strb    (strb)
  );

  mfmt_rx_datapath #(.NUM_LANES(NUM_LANES), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sdIn        (sdIn),
    .strb        (strb),
    .sampleValid (sampleValid),
    .samples     (samples)
  );

endmodule

// File: rtl/mfmt_audio_rx_chk.sv
module mfmt_audio_rx_chk #(
  parameter int NUM_LANES = 3,
  parameter int SAMPLE_W  = 24
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            useReg,
  input logic [1:0]                      pinFmt,
  input logic [2:0]                      regFmt,
  input logic                            sampleValid,
  input logic [2*NUM_LANES*SAMPLE_W-1:0] samples
);

  logic resvSel;
  assign resvSel = useReg && (regFmt[2:1] == 2'b11);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(samples));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && resvSel && $past(resvSel)) |-> (samples == '0));

  a_r10_fmt_change_disarms: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({useReg, pinFmt, regFmt}) |=> !sampleValid);

  a_r11_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sampleValid && samples == '0));

endmodule

bind mfmt_audio_rx mfmt_audio_rx_chk #(.NUM_LANES(NUM_LANES), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .useReg      (useReg),
  .pinFmt      (pinFmt),
  .regFmt      (regFmt),
  .sampleValid (sampleValid),
  .samples     (samples)
);

// File: tb/mfmt_audio_rx_tb.sv
module mfmt_audio_rx_tb;

  localparam int NL = 3;
  localparam int SW = 24;
  localparam int M_I2S = 0, M_MSBJ = 1, M_LSBJ = 2, M_OFF = 3;

  typedef struct packed {
    logic       useReg;
    logic [1:0] pin;
    logic [2:0] rg;
    logic [5:0] half;
    logic [4:0] len;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b00, 3'b000, 6'd32, 5'd24},
    '{1'b0, 2'b01, 3'b111, 6'd32, 5'd24},
    '{1'b0, 2'b10, 3'b000, 6'd32, 5'd24},
    '{1'b0, 2'b11, 3'b110, 6'd32, 5'd24},
    '{1'b1, 2'b00, 3'b010, 6'd32, 5'd24},
    '{1'b1, 2'b01, 3'b100, 6'd32, 5'd24},
    '{1'b1, 2'b11, 3'b000, 6'd24, 5'd24},
    '{1'b1, 2'b00, 3'b110, 6'd32, 5'd24},
    '{1'b1, 2'b00, 3'b100, 6'd24, 5'd16},
    '{1'b1, 2'b10, 3'b001, 6'd32, 5'd24},
    '{1'b1, 2'b00, 3'b011, 6'd32, 5'd24},
    '{1'b1, 2'b00, 3'b101, 6'd32, 5'd24},
    '{1'b1, 2'b00, 3'b111, 6'd32, 5'd24},
    '{1'b0, 2'b00, 3'b000, 6'd32, 5'd16}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic wordSel = 1'b0;
  logic [NL-1:0] sdIn = '0;
  logic useReg = 1'b0;
  logic [1:0] pinFmt = 2'b00;
  logic [2:0] regFmt = 3'b000;
  logic sampleValid;
  logic [2*NL*SW-1:0] samples;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int wide = 0;
  logic prevV = 1'b0;
  logic [2*NL*SW-1:0] snap = '0;
  logic [SW-1:0] wd [6];

  always #2 clk = ~clk;

  mfmt_audio_rx #(.NUM_LANES(NL), .SAMPLE_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel), .sdIn(sdIn),
    .useReg(useReg), .pinFmt(pinFmt), .regFmt(regFmt),
    .sampleValid(sampleValid), .samples(samples)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      pulses = pulses + 1;
      snap   = samples;
      if (prevV) wide = wide + 1;
    end
    prevV = rstN && sampleValid;
  end

  task automatic check(input string tag, input string what, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic checkInt(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  function automatic void decode(input logic u, input logic [1:0] p, input logic [2:0] r,
                                 output int mode, output int len);
    len = 24;
    if (!u) begin
      mode = (p == 2'b00) ? M_I2S : M_LSBJ;
      if (p == 2'b01) len = 16;
      if (p == 2'b10) len = 20;
    end else begin
      case (r)
        3'b000: mode = M_I2S;
        3'b001: begin mode = M_LSBJ; len = 16; end
        3'b010: begin mode = M_LSBJ; len = 18; end
        3'b011: begin mode = M_LSBJ; len = 20; end
        3'b100: mode = M_MSBJ;
        3'b101: mode = M_LSBJ;
        default: mode = M_OFF;
      endcase
    end
  endfunction

  function automatic logic [SW-1:0] mkWord(input int i, input int c, input int len);
    logic [SW-1:0] w, m;
    w = 24'h5A3C96 ^ (24'(i) * 24'h0F1E2D) ^ (24'(c + 1) * 24'h3B4A59);
    m = 24'hFFFFFF >> (24 - len);
    return (w & m) | (24'd1 << (len - 1)) | 24'd1;
  endfunction

  function automatic logic stimBit(input int mode, input int len, input int h, input int s,
                                   input logic [SW-1:0] lw, input logic [SW-1:0] rw);
    int k;
    if (mode == M_I2S) begin
      k = s - 1;
      if (k >= 0 && k < len) return lw[len-1-k];
      k = s - h - 1;
      if (k >= 0 && k < len) return rw[len-1-k];
    end else if (mode == M_LSBJ) begin
      k = s - (h - len);
      if (s < h && k >= 0 && k < len) return lw[len-1-k];
      k = s - (2*h - len);
      if (s < 2*h && k >= 0 && k < len) return rw[len-1-k];
    end else begin
      k = s;
      if (s < h && k < len) return lw[len-1-k];
      k = s - h;
      if (s < 2*h && k >= 0 && k < len) return rw[len-1-k];
    end
    return 1'b0;
  endfunction

  task automatic slot(input logic ws, input logic [NL-1:0] sd);
    @(negedge clk);
    bitClk  = 1'b0;
    wordSel = ws;
    sdIn    = sd;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    bitClk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic runVec(input int i);
    vec_t v;
    int mode, dlen, slen, smode, h, base;
    logic lvl;
    logic [NL-1:0] sd;
    logic [SW-1:0] exp;
    string ctag, mtag;
    v = VECS[i];
    decode(v.useReg, v.pin, v.rg, mode, dlen);
    slen  = (mode == M_LSBJ) ? dlen : int'(v.len);
    smode = (mode == M_OFF) ? M_MSBJ : mode;
    h     = int'(v.half);
    for (int c = 0; c < 6; c++) wd[c] = mkWord(i, c, slen);
    useReg = v.useReg; pinFmt = v.pin; regFmt = v.rg;
    doReset();
    base = pulses;
    lvl = (mode == M_I2S) ? 1'b0 : 1'b1;
    slot(~lvl, '0);
    for (int s = 0; s <= 2*h; s++) begin
      for (int k = 0; k < NL; k++) sd[k] = stimBit(smode, slen, h, s, wd[2*k], wd[2*k+1]);
      slot((s < h || s == 2*h) ? lvl : ~lvl, sd);
    end
    @(negedge clk); bitClk = 1'b0;
    repeat (6) @(negedge clk);
    ctag = v.useReg ? "R2" : "R1";
    mtag = (mode == M_I2S) ? "R3" : (mode == M_MSBJ) ? "R4" : (mode == M_LSBJ) ? "R5" : "R9";
    checkInt("R8", $sformatf("vec%0d pulse count", i), pulses - base, 1);
    // R6 left alignment and R7 channel placement on every channel
    for (int c = 0; c < 6; c++) begin
      exp = (mode == M_OFF) ? '0 : (wd[c] << (24 - slen));
      check({ctag, "/", mtag, "/R6/R7"}, $sformatf("vec%0d ch%0d", i, c + 1),
            snap[c*SW +: SW], exp);
    end
  endtask

  initial begin
    int base;
    // R11 reset state while held in reset
    repeat (3) @(negedge clk);
    checkInt("R11", "valid in reset", int'(sampleValid), 0);
    check("R11", "samples in reset ch1", samples[SW-1:0], '0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkInt("R11", "valid after reset", int'(sampleValid), 0);
    check("R11", "samples after reset ch6", samples[5*SW +: SW], '0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R10: a right word right after arming must not publish
    useReg = 1'b0; pinFmt = 2'b00; regFmt = 3'b000;
    doReset();
    base = pulses;
    slot(1'b1, '0); slot(1'b1, '0);
    slot(1'b0, 3'b111); slot(1'b0, '0);
    repeat (6) @(negedge clk);
    checkInt("R10", "no pulse before left word", pulses - base, 0);
    slot(1'b1, 3'b101); slot(1'b1, '0);
    slot(1'b0, 3'b010); slot(1'b0, '0);
    repeat (6) @(negedge clk);
    checkInt("R10", "pulse after left then right", pulses - base, 1);

    // R10: format change mid-frame disarms
    useReg = 1'b0; pinFmt = 2'b00; regFmt = 3'b000;
    doReset();
    base = pulses;
    slot(1'b1, '0);
    for (int s = 0; s <= 64; s++) begin
      if (s == 34) pinFmt = 2'b01;
      slot((s < 32 || s == 64) ? 1'b0 : 1'b1, (s % 3 == 0) ? 3'b111 : 3'b000);
    end
    repeat (6) @(negedge clk);
    checkInt("R10", "no pulse after format change", pulses - base, 0);

    checkInt("R8", "valid wider than one cycle", wide, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule